// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block keeps track of load-exclusive / store-exclusive pairs for a small group of processors sharing memory. Each cycle at most one request reaches it: a load-exclusive, a store-exclusive or a clear-exclusive. Every request carries the issuing processor's ID, an already-translated physical address, an access size, a flag saying whether the location is shared, and a condition-pass bit. A request whose condition bit is low is dropped.

Two kinds of state sit inside. The first is a per-processor local monitor, a two-state machine with the states `LM_OPEN` and `LM_EXCL`. Transition `LOAD_GO` moves it to `LM_EXCL`. Transitions `STORE_GO` and `CLEAR_GO` move it back to `LM_OPEN`. The second is a global reservation table with one entry per processor. Each entry is a two-state machine with the states `RV_EMPTY` and `RV_HELD`. Transition `TAG` (a shared load) moves the entry to `RV_HELD` and stores the address and size. Transition `DROP` (a passing shared store that hits the entry) returns it to `RV_EMPTY`.

Every store-exclusive is answered one cycle later with a status. A status of 0 means pass, and the write-enable is raised. A status of 1 means fail. The same size and tag logic serves every access width. No address alignment check is made.

Top module: `excl_monitor`

## Requirements
- R1: A synchronous active-high reset opens every local monitor and empties every global reservation. After reset, no response or write-enable is raised, and a store-exclusive from any processor fails.
- R2: A request with `req_cond`=0, with `req_op`=3 (reserved) or with `req_valid`=0 changes no monitor state. A store carrying `req_cond`=0 produces no response.
- R3: A load-exclusive (`req_op`=0) puts the issuer's local monitor into the exclusive state. A following non-shared store-exclusive (`req_op`=1) from that processor passes. A non-shared load leaves the global table untouched.
- R4: A store-exclusive from a processor whose local monitor is open fails with status 1 and no write-enable. Local monitors are private, so a load by one processor does not let another processor's store pass.
- R5: Every store-exclusive, pass or fail, returns the issuer's local monitor to open.
- R6: A shared load-exclusive tags the issuer's global entry with address and size. A shared store-exclusive passes only if the local monitor is exclusive and the issuer's entry is held with an equal address and equal size. A failing store leaves the entry held.
- R7: A passing shared store empties the issuer's own global entry.
- R8: Each processor holds one global entry. A newer shared load replaces the older address and size.
- R9: A passing shared store also empties every other processor's entry that holds the same address. Entries with other addresses are kept. A non-shared store empties no entry.
- R10: A clear-exclusive (`req_op`=2) opens the issuer's local monitor and leaves its global entry unchanged.
- R11: All sizes (`req_size` 0 byte, 1 halfword, 2 word, 3 doubleword) share the same monitors. Any address, odd ones included, is accepted without a fault.
- R12: The response to a store issued in cycle N appears in cycle N+1. It carries `rsp_valid`=1, `rsp_id` equal to the issuer and `rsp_fail` as the status. `wr_en` is raised only with a passing response. No response appears without a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load-exclusive, 1 store-exclusive, 2 clear-exclusive, 3 reserved |
| req_id | input | ID_W | Issuing processor |
| req_addr | input | ADDR_W | Physical address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_shared | input | 1 | Location is shared memory |
| req_cond | input | 1 | Condition passed; 0 makes the request a no-op |
| rsp_valid | output | 1 | Store status valid |
| rsp_id | output | ID_W | Processor the status belongs to |
| rsp_fail | output | 1 | Status: 0 pass, 1 fail |
| wr_en | output | 1 | Memory write permitted for the store |

## Verification
The bench builds the block with `NUM_PROCS`=3 and `ADDR_W`=16. A processor count that is not a power of two leaves one ID code unused. It also lets three processors contend in one scenario: two hold the same address and one holds a different address, so the clearing of other processors' entries is checked in both directions. The narrow address keeps odd, unaligned addresses easy to read in the stimulus. Every size code is still exercised, including a size mismatch on an equal address.

// File: rtl/excl_pkg.sv
package excl_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_CLEAR = 2'd2,
        OP_RSVD  = 2'd3
    } excl_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } excl_size_e;

    typedef enum logic {
        LM_OPEN = 1'b0,
        LM_EXCL = 1'b1
    } lmon_state_e;

    typedef enum logic {
        RV_EMPTY = 1'b0,
        RV_HELD  = 1'b1
    } resv_state_e;

endpackage

// File: rtl/excl_local_mon.sv
module excl_local_mon
    import excl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_go,
    input  logic close_go,
    output logic excl
);

    lmon_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LM_OPEN;
        else     state_q <= state_d;
    end

    // transitions: LOAD_GO -> LM_EXCL, STORE_GO/CLEAR_GO -> LM_OPEN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LM_OPEN: if (load_go)  state_d = LM_EXCL;
            LM_EXCL: if (close_go) state_d = LM_OPEN;
            default: state_d = LM_OPEN;
        endcase
    end

    always_comb excl = (state_q == LM_EXCL);

endmodule

// File: rtl/excl_resv_entry.sv
module excl_resv_entry
    import excl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tag_go,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [1:0]        tag_size,
    input  logic              drop_go,
    output logic              held,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        size
);

    resv_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RV_EMPTY;
        else     state_q <= state_d;
    end

    // TAG wins over DROP; both cannot come from one request anyway
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RV_EMPTY: if (tag_go) state_d = RV_HELD;
            RV_HELD: begin
                if (tag_go)       state_d = RV_HELD;
                else if (drop_go) state_d = RV_EMPTY;
            end
            default: state_d = RV_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            size <= '0;
        end else if (tag_go) begin
            addr <= tag_addr;
            size <= tag_size;
        end
    end

    always_comb held = (state_q == RV_HELD);

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_pkg::*;
#(
    parameter int NUM_PROCS = 4,
    parameter int ADDR_W    = 32,
    parameter int ID_W      = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_shared,
    input  logic              req_cond,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic              rsp_fail,
    output logic              wr_en
);

    logic                 id_ok, go, ld_go, st_go, cl_go;
    logic                 own_excl, own_hit, st_pass, st_pass_sh;
    logic [NUM_PROCS-1:0] lm_excl, gr_valid, addr_hit, sel;
    logic [ADDR_W-1:0]    gr_addr [NUM_PROCS];
    logic [1:0]           gr_size [NUM_PROCS];

    // request decode
    always_comb begin
        id_ok = (int'(req_id) < NUM_PROCS);
        go    = req_valid && req_cond && id_ok;
        ld_go = go && (req_op == OP_LOAD);
        st_go = go && (req_op == OP_STORE);
        cl_go = go && (req_op == OP_CLEAR);
    end

    // per-processor monitors
    for (genvar p = 0; p < NUM_PROCS; p++) begin : g_proc
        assign sel[p]      = (int'(req_id) == p);
        assign addr_hit[p] = gr_valid[p] && (gr_addr[p] == req_addr);

        excl_local_mon u_lmon (
            .clk      (clk),
            .rst      (rst),
            .load_go  (ld_go && sel[p]),
            .close_go ((st_go || cl_go) && sel[p]),
            .excl     (lm_excl[p])
        );

        excl_resv_entry #(.ADDR_W(ADDR_W)) u_resv (
            .clk      (clk),
            .rst      (rst),
            .tag_go   (ld_go && req_shared && sel[p]),
            .tag_addr (req_addr),
            .tag_size (req_size),
            .drop_go  (st_pass_sh && (sel[p] || addr_hit[p])),
            .held     (gr_valid[p]),
            .addr     (gr_addr[p]),
            .size     (gr_size[p])
        );
    end

    // store decision
    always_comb begin
        own_excl   = id_ok && lm_excl[req_id];
        own_hit    = id_ok && addr_hit[req_id] && (gr_size[req_id] == req_size);
        st_pass    = st_go && own_excl && (!req_shared || own_hit);
        st_pass_sh = st_pass && req_shared;
    end

    // registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_fail  <= 1'b0;
            wr_en     <= 1'b0;
        end else begin
            rsp_valid <= st_go;
            rsp_id    <= req_id;
            rsp_fail  <= st_go && !st_pass;
            wr_en     <= st_pass;
        end
    end

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
    parameter int NUM_PROCS = 4,
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [1:0]           req_op,
    input logic [ID_W-1:0]      req_id,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 req_shared,
    input logic                 req_cond,
    input logic                 rsp_valid,
    input logic                 rsp_fail,
    input logic                 wr_en,
    input logic [NUM_PROCS-1:0] lm_excl,
    input logic [NUM_PROCS-1:0] gr_valid
);

    logic live, ld, st;
    always_comb begin
        live = req_valid && req_cond && (int'(req_id) < NUM_PROCS);
        ld   = live && (req_op == 2'd0);
        st   = live && (req_op == 2'd1);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !rsp_valid && !wr_en); // R1
    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (lm_excl == '0) && (gr_valid == '0)); // R1
    AST_NOCOND_STILL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_cond) |=> $stable(lm_excl) && $stable(gr_valid) && !rsp_valid); // R2
    AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (rst)
        ld |=> lm_excl[$past(req_id)]); // R3
    AST_LOCAL_LOAD_NO_TAG: assert property (@(posedge clk) disable iff (rst)
        (ld && !req_shared) |=> $stable(gr_valid)); // R3
    AST_OPEN_FAILS: assert property (@(posedge clk) disable iff (rst)
        (st && !lm_excl[req_id]) |=> rsp_valid && rsp_fail && !wr_en); // R4
    AST_STORE_OPENS: assert property (@(posedge clk) disable iff (rst)
        st |=> !lm_excl[$past(req_id)]); // R5
    AST_SHARED_NEEDS_TAG: assert property (@(posedge clk) disable iff (rst)
        (st && req_shared && !gr_valid[req_id]) |=> rsp_fail); // R6
    AST_WREN_ON_PASS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> rsp_valid && !rsp_fail); // R12
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        !st |=> !rsp_valid); // R12

endmodule

bind excl_monitor excl_monitor_chk #(
    .NUM_PROCS (NUM_PROCS),
    .ADDR_W    (ADDR_W),
    .ID_W      (ID_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_id     (req_id),
    .req_addr   (req_addr),
    .req_shared (req_shared),
    .req_cond   (req_cond),
    .rsp_valid  (rsp_valid),
    .rsp_fail   (rsp_fail),
    .wr_en      (wr_en),
    .lm_excl    (lm_excl),
    .gr_valid   (gr_valid)
);

// File: tb/excl_monitor_test.sv
module excl_monitor_test;

    localparam int NP = 3;
    localparam int AW = 16;
    localparam int IW = 2;
    localparam int OP_LD = 0, OP_ST = 1, OP_CL = 2, OP_RS = 3;
    localparam int SZ_B = 0, SZ_H = 1, SZ_W = 2, SZ_D = 3;
    localparam bit PASS = 1'b0, FAILS = 1'b1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [IW-1:0] req_id = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_shared = 1'b0;
    logic          req_cond = 1'b0;
    logic          rsp_valid, rsp_fail, wr_en;
    logic [IW-1:0] rsp_id;

    int total = 0;
    int failed = 0;
    int cyc = 0;
    bit started = 1'b0;

    typedef struct {
        int    id;
        bit    fail;
        int    due;
        string tag;
    } exp_t;
    exp_t sb[$];
    exp_t e;

    always #10 clk = ~clk;   // 50 MHz

    excl_monitor #(.NUM_PROCS(NP), .ADDR_W(AW), .ID_W(IW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_id(req_id), .req_addr(req_addr), .req_size(req_size),
        .req_shared(req_shared), .req_cond(req_cond), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .rsp_fail(rsp_fail), .wr_en(wr_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops the scoreboard when a response is due
    always @(negedge clk) begin
        if (started) begin
            total++;
            if (sb.size() > 0 && sb[0].due == cyc) begin
                e = sb.pop_front();
                if (!(rsp_valid === 1'b1 && rsp_fail === e.fail &&
                      rsp_id === IW'(e.id) && wr_en === !e.fail)) begin
                    failed++;
                    $display("FAIL %s: valid=%b fail=%b id=%0d wr_en=%b, expected valid=1 fail=%b id=%0d wr_en=%b",
                             e.tag, rsp_valid, rsp_fail, rsp_id, wr_en, e.fail, e.id, !e.fail);
                end
            end else if (rsp_valid !== 1'b0 || wr_en !== 1'b0) begin
                failed++;
                $display("FAIL R12 no store due: valid=%b wr_en=%b, expected valid=0 wr_en=0",
                         rsp_valid, wr_en);
            end
        end
    end

    task automatic req(input int op, input int id, input int addr, input int sz,
                       input bit sh, input bit cnd, input bit exp_fail, input string tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = 2'(op);
        req_id     = IW'(id);
        req_addr   = AW'(addr);
        req_size   = 2'(sz);
        req_shared = sh;
        req_cond   = cnd;
        if (op == OP_ST && cnd) sb.push_back('{id: id, fail: exp_fail, due: cyc + 1, tag: tag});
    endtask

    task automatic ld(input int id, input int addr, input int sz, input bit sh);
        req(OP_LD, id, addr, sz, sh, 1'b1, PASS, "");
    endtask

    task automatic st(input int id, input int addr, input int sz, input bit sh,
                      input bit exp_fail, input string tag);
        req(OP_ST, id, addr, sz, sh, 1'b1, exp_fail, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1'b1;          // R1: monitor first sees the reset state quiet
        idle();

        // R1: nothing reserved after reset
        st(0, 'h10, SZ_W, 0, FAILS, "R1 p0 store after reset");
        st(1, 'h10, SZ_W, 1, FAILS, "R1 p1 shared store after reset");

        // R3 / R11: byte load, word store, odd address
        ld(0, 'h21, SZ_B, 0);
        st(0, 'h21, SZ_W, 0, PASS, "R3 R11 local pass across sizes");
        // R5: store opened the monitor
        st(0, 'h21, SZ_W, 0, FAILS, "R5 second store fails");

        // R4: monitors are private
        ld(1, 'h30, SZ_W, 0);
        st(2, 'h30, SZ_W, 0, FAILS, "R4 other processor store fails");
        st(1, 'h30, SZ_W, 0, PASS, "R4 own monitor untouched");

        // R2: condition failed / reserved op do nothing
        req(OP_LD, 0, 'h50, SZ_W, 0, 1'b0, PASS, "");
        st(0, 'h50, SZ_W, 0, FAILS, "R2 cond-failed load ignored");
        ld(1, 'h51, SZ_H, 0);
        req(OP_ST, 1, 'h51, SZ_H, 0, 1'b0, PASS, "");   // R2: no response expected
        st(1, 'h51, SZ_H, 0, PASS, "R2 cond-failed store ignored");
        ld(2, 'h52, SZ_W, 0);
        req(OP_CL, 2, 'h52, SZ_W, 0, 1'b0, PASS, "");
        req(OP_RS, 2, 'h52, SZ_W, 0, 1'b1, PASS, "");
        st(2, 'h52, SZ_W, 0, PASS, "R2 cond-failed clear and reserved op ignored");

        // R10: clear opens local, keeps global
        ld(2, 'h60, SZ_W, 0);
        req(OP_CL, 2, 'h60, SZ_W, 0, 1'b1, PASS, "");
        st(2, 'h60, SZ_W, 0, FAILS, "R10 clear opens local monitor");
        ld(0, 'h103, SZ_H, 1);
        req(OP_CL, 0, 'h103, SZ_H, 0, 1'b1, PASS, "");
        ld(0, 'h500, SZ_W, 0);
        st(0, 'h103, SZ_H, 1, PASS, "R10 clear keeps global entry");

        // R6: address and size must match; failure keeps the tag
        ld(1, 'h200, SZ_W, 1);
        st(1, 'h204, SZ_W, 1, FAILS, "R6 address mismatch");
        ld(1, 'h7, SZ_B, 0);
        st(1, 'h200, SZ_W, 1, PASS, "R6 tag kept after failed store");
        // R7: own tag emptied by the pass
        ld(1, 'h7, SZ_B, 0);
        st(1, 'h200, SZ_W, 1, FAILS, "R7 own entry emptied");
        ld(2, 'h300, SZ_W, 1);
        st(2, 'h300, SZ_B, 1, FAILS, "R11 size mismatch on shared store");

        // R8: newer shared load replaces older
        ld(0, 'h400, SZ_D, 1);
        ld(0, 'h480, SZ_D, 1);
        st(0, 'h400, SZ_D, 1, FAILS, "R8 old address replaced");
        ld(0, 'h1, SZ_B, 0);
        st(0, 'h480, SZ_D, 1, PASS, "R8 new address held");

        // R9: pass clears same-address entries of others only
        ld(0, 'h600, SZ_W, 1);
        ld(1, 'h600, SZ_W, 1);
        ld(2, 'h700, SZ_W, 1);
        st(0, 'h600, SZ_W, 1, PASS, "R9 first owner passes");
        st(1, 'h600, SZ_W, 1, FAILS, "R9 same address cleared");
        st(2, 'h700, SZ_W, 1, PASS, "R9 other address kept");
        ld(0, 'h800, SZ_W, 1);
        ld(1, 'h800, SZ_W, 0);
        st(1, 'h800, SZ_W, 0, PASS, "R9 non-shared store passes");
        st(0, 'h800, SZ_W, 1, PASS, "R9 non-shared store empties nothing");

        repeat (4) idle();
        total++;
        if (sb.size() != 0) begin
            failed++;
            $display("FAIL R12 missing responses: pending=%0d, expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule